// File: doc/BRIEF.md
# Phase-Accumulator Sine Synthesizer

This block is a numerically controlled oscillator that feeds an excitation DAC with a stream of digital sine samples. The master clock is divided by four into a clock enable. On each enable a 27-bit phase accumulator adds a programmable step. The top 12 bits of the phase address a sine table, and the table returns a 10-bit offset-binary amplitude code. The output frequency is the step times a quarter of the master clock rate, divided by 2^27.

Software builds the step in 9-bit segments in a staging register. A separate commit strobe copies the whole staged word into the active step register, so the accumulator never adds a half-written word. A commit never clears the accumulator, so the waveform keeps its phase when the frequency changes. The table stores one quarter of a wave. The other three quarters come from mirroring the index and negating the amplitude about mid-scale.

Top module: `nco_sine_gen`

## Requirements
- R1: A synchronous active-high reset clears the phase accumulator, the divide-by-four counter, the staging register and the active step. After reset, `sample_o` is 512 and `valid_o` is 0. When `en_i` is raised on the first clock after reset, the first `valid_o` pulse appears after the fifth rising edge.
- R2: While `en_i` is high, the phase advances once every 4 clocks. While `en_i` is low, the divide-by-four counter holds, no advance occurs and `valid_o` stays 0.
- R3: Each advance adds the active step to the accumulator, modulo 2^27.
- R4: The table address is accumulator bits [26:15]. For address a, the sample is 512 + round(511·sin(2π(a+0.5)/4096)), with ties rounded away from zero.
- R5: `valid_o` is a one-clock pulse on the clock after each advance edge. `sample_o` carries the sample for the new phase at the same time, and holds its value whenever `valid_o` is low.
- R6: A write with `freq_sel_i` = k (k = 0, 1, 2) loads `freq_data_i` into staging bits [9k+8:9k]. A write with `freq_sel_i` = 3 changes nothing.
- R7: `freq_commit_i` copies the staging register into the active step. Staged writes that are not committed do not change the step in use.
- R8: A commit leaves the accumulator untouched. The new step is used from the first advance whose edge follows the commit edge.
- R9: A step of 0 holds the phase constant. The largest step, 2^27−1, wraps so that the phase moves back by one unit per advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable for the divider and the accumulator |
| freq_wr_i | input | 1 | Staging segment write strobe |
| freq_sel_i | input | 2 | Index of the segment to write |
| freq_data_i | input | 9 | Segment data |
| freq_commit_i | input | 1 | Copy the staged word into the active step |
| sample_o | output | 10 | Offset-binary sine sample |
| valid_o | output | 1 | One-clock strobe marking a new sample |

## Verification
The assertions check the following on every cycle:
- the divider counter stays in range and freezes while the block is disabled;
- an advance never follows another advance on the next clock;
- the accumulator moves only on an advance and is left alone by a commit;
- the active step moves only on a commit;
- an out-of-range segment write leaves the staging register alone;
- `valid_o` is a single-clock pulse, and the sample holds between pulses.

Only the bench scenarios can show that the sample values match the sine formula across all 4096 addresses. The same holds for the wrap behaviour at the extreme steps, the exact point at which a committed step takes over, and the five-edge latency after reset.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam real PI = 3.141592653589793;

  // Number of write segments needed to cover a word of width w with segments of width s.
  function automatic int seg_count(int w, int s);
    return (w + s - 1) / s;
  endfunction

  // Magnitude of one quarter-wave entry, sampled at mid-bin, rounded half away from zero.
  function automatic int quarter_mag(int k, int addr_w, int amp_w);
    real ang;
    real peak;
    ang  = 2.0 * PI * (real'(k) + 0.5) / real'(2 ** addr_w);
    peak = real'((2 ** (amp_w - 1)) - 1);
    return int'(peak * $sin(ang));
  endfunction

endpackage

// File: rtl/nco_step_reg.sv
module nco_step_reg #(
  parameter int PHASE_W = 27,
  parameter int SEG_W   = 9,
  parameter int NSEG    = nco_pkg::seg_count(PHASE_W, SEG_W),
  parameter int SEL_W   = (NSEG > 1) ? $clog2(NSEG + 1) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [SEG_W-1:0]   data_i,
  input  logic               commit_i,
  output logic [PHASE_W-1:0] step_o
);
  localparam int STG_W = NSEG * SEG_W;

  logic [STG_W-1:0]   staging_q;
  logic [PHASE_W-1:0] step_q;
  logic               sel_out_of_range;

  assign sel_out_of_range = int'(sel_i) >= NSEG;

  always_ff @(posedge clk) begin
    if (rst) begin
      staging_q <= '0;
    end else if (wr_i) begin
      for (int g = 0; g < NSEG; g++) begin
        if (sel_i == SEL_W'(g)) staging_q[g*SEG_W +: SEG_W] <= data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else if (commit_i) step_q <= staging_q[PHASE_W-1:0];
  end

  assign step_o = step_q;

  // R7
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(step_q));

  // R6
  bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_out_of_range) |=> $stable(staging_q));

endmodule

// File: rtl/nco_clk_div.sv
module nco_clk_div #(
  parameter int DIV   = 4,
  parameter int DIV_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (en_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R2
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cnt_q));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] acc_o,
  output logic               adv_o
);
  logic [PHASE_W-1:0] acc_q;
  logic               adv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= tick_i;
      if (tick_i) acc_q <= acc_q + step_i;
    end
  end

  assign acc_o = acc_q;
  assign adv_o = adv_q;

  // R3
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(acc_q));

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AMP_W-1:0]  sample_o,
  output logic              valid_o
);
  localparam int QW    = ADDR_W - 2;
  localparam int QN    = 2 ** QW;
  localparam int MAG_W = AMP_W - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(2 ** (AMP_W - 1));

  logic [MAG_W-1:0] qrom [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    assign qrom[k] = MAG_W'(nco_pkg::quarter_mag(k, ADDR_W, AMP_W));
  end

  logic [1:0]       quad;
  logic [QW-1:0]    lin;
  logic [QW-1:0]    idx;
  logic [AMP_W-1:0] mag_ext;
  logic [AMP_W-1:0] next_sample;

  assign quad        = addr_i[ADDR_W-1 -: 2];
  assign lin         = addr_i[QW-1:0];
  assign idx         = quad[0] ? ~lin : lin;
  assign mag_ext     = {1'b0, qrom[idx]};
  assign next_sample = quad[1] ? (MID - mag_ext) : (MID + mag_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= MID;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= adv_i;
      if (adv_i) sample_o <= next_sample;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R5
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sample_o));

endmodule

// File: rtl/nco_sine_gen.sv
module nco_sine_gen #(
  parameter int PHASE_W = 27,
  parameter int ADDR_W  = 12,
  parameter int AMP_W   = 10,
  parameter int DIV     = 4,
  parameter int SEG_W   = 9,
  parameter int NSEG    = nco_pkg::seg_count(PHASE_W, SEG_W),
  parameter int SEL_W   = (NSEG > 1) ? $clog2(NSEG + 1) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             freq_wr_i,
  input  logic [SEL_W-1:0] freq_sel_i,
  input  logic [SEG_W-1:0] freq_data_i,
  input  logic             freq_commit_i,
  output logic [AMP_W-1:0] sample_o,
  output logic             valid_o
);
  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] acc;
  logic [ADDR_W-1:0]  lut_addr;
  logic               tick;
  logic               adv;

  nco_step_reg #(.PHASE_W(PHASE_W), .SEG_W(SEG_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_step (
    .clk(clk), .rst(rst), .wr_i(freq_wr_i), .sel_i(freq_sel_i),
    .data_i(freq_data_i), .commit_i(freq_commit_i), .step_o(step)
  );

  nco_clk_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .en_i(en_i), .tick_o(tick)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .tick_i(tick), .step_i(step), .acc_o(acc), .adv_o(adv)
  );

  assign lut_addr = acc[PHASE_W-1 -: ADDR_W];

  nco_sine_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_lut (
    .clk(clk), .rst(rst), .adv_i(adv), .addr_i(lut_addr),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  // R8
  commit_keeps_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_commit_i && !tick) |=> $stable(acc));

  // R2
  no_valid_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !adv) |=> !valid_o);

endmodule

// File: tb/nco_sine_gen_tb.sv
module nco_sine_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic       freq_wr_i = 1'b0;
  logic [1:0] freq_sel_i = '0;
  logic [8:0] freq_data_i = '0;
  logic       freq_commit_i = 1'b0;
  logic [9:0] sample_o;
  logic       valid_o;

  int n_chk = 0;
  int n_err = 0;

  logic [26:0] acc_m;
  logic [26:0] step_m;
  logic [26:0] stg_m;
  logic [9:0]  last_samp;

  nco_sine_gen u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .freq_wr_i(freq_wr_i),
    .freq_sel_i(freq_sel_i), .freq_data_i(freq_data_i),
    .freq_commit_i(freq_commit_i), .sample_o(sample_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_samp(logic [26:0] a);
    int   ad;
    real  x;
    int   r;
    ad = int'(a[26:15]);
    x  = 511.0 * $sin(2.0 * 3.141592653589793 * (real'(ad) + 0.5) / 4096.0);
    if (x >= 0.0) r = $rtoi(x + 0.5);
    else          r = -$rtoi(-x + 0.5);
    return 512 + r;
  endfunction

  task automatic wr(int sel, int data);
    @(posedge clk); #1;
    freq_wr_i = 1'b1; freq_sel_i = 2'(sel); freq_data_i = 9'(data);
    @(posedge clk); #1;
    freq_wr_i = 1'b0;
    if (sel < 3) stg_m[sel*9 +: 9] = 9'(data);
  endtask

  task automatic commit();
    @(posedge clk); #1;
    freq_commit_i = 1'b1;
    @(posedge clk); #1;
    freq_commit_i = 1'b0;
    step_m = stg_m;
  endtask

  task automatic load_step(logic [26:0] v);
    for (int s = 0; s < 3; s++) wr(s, int'(v[s*9 +: 9]));
    commit();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; en_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    acc_m = '0; step_m = '0; stg_m = '0; last_samp = 10'd512;
    @(negedge clk);
    chk(sample_o == 10'd512, "R1 reset sample", int'(sample_o), 512);
    chk(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
  endtask

  // Run until n samples; checks spacing (R2), value (R3/R4), hold (R5).
  task automatic run(int n, bit first_lat, string tag);
    int  seen = 0;
    int  since = 0;
    bit  have = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    while (seen < n) begin
      @(negedge clk);
      since++;
      if (valid_o) begin
        if (first_lat && seen == 0)
          chk(since == 5, "R1 first sample latency", since, 5);
        if (have) chk(since == 4, "R2 sample spacing", since, 4);
        have = 1'b1;
        since = 0;
        acc_m = acc_m + step_m;
        chk(int'(sample_o) == exp_samp(acc_m), {"R4 sample value ", tag},
            int'(sample_o), exp_samp(acc_m));
        last_samp = sample_o;
        seen++;
      end else begin
        chk(sample_o == last_samp, "R5 sample hold", int'(sample_o), int'(last_samp));
      end
    end
    en_i = 1'b0;
  endtask

  initial begin
    int vcount;
    do_reset();

    // R2: disabled block emits nothing
    vcount = 0;
    repeat (40) begin
      @(negedge clk);
      if (valid_o) vcount++;
    end
    chk(vcount == 0, "R2 idle no valid", vcount, 0);

    // R3/R4: full address sweep, one address per advance
    load_step(27'd1 << 15);
    run(4096, 1'b1, "R3 sweep");

    // R7: staged but uncommitted write has no effect
    wr(0, 511);
    run(20, 1'b0, "R7 uncommitted");
    // R8: commit keeps phase, new step used at next advance
    commit();
    run(300, 1'b0, "R8 after commit");

    // R6: segment index 3 ignored
    wr(3, 9'h1AB);
    commit();
    run(50, 1'b0, "R6 bad select");

    // R3: irregular step
    load_step(27'd123457);
    run(2000, 1'b0, "R3 odd step");

    // R9: maximum step wraps backwards
    load_step(27'h7FF_FFFF);
    run(600, 1'b0, "R9 max step");

    // R9: zero step holds phase
    load_step(27'd0);
    run(50, 1'b0, "R9 zero step");

    // R3: large step near half cycle
    load_step((27'd1 << 26) + 27'd3);
    run(200, 1'b0, "R3 half step");

    // R1: reset mid-run clears accumulator and step
    do_reset();
    run(10, 1'b1, "R1 zero after reset");
    load_step(27'd1 << 15);
    run(10, 1'b0, "R1 acc cleared");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule